// File: doc/BRIEF.md
# Rotating-Window Cartridge Bank Mapper

This block sits between a 68000-style CPU address bus and a cartridge ROM. It splits the low address space into eight windows of 256 KB. Each window is translated to a ROM bank through three byte-wide control registers. Software programs those registers by writing into the low 64 KB of cartridge space. Address bits [11:8] pick which register is written.

A bank index held in the bank register chooses a ROM bank. A mode bit then decides how the windows use it:
- In rotating mode, window w is served from bank (index + w) mod 8.
- In mirrored mode, every window shows the bank named by the index.

A bit of the SRAM register drives an SRAM-mapped flag. Reads of the cartridge I/O page return the upper nibble of the bank register.

Bit 7 of the mode register acts as a write enable. Once software clears it, every later register write is dropped until reset, so the mapper can lock itself.

The write port and the read port are plain strobes with no back-pressure:
- A write is taken in the clock cycle in which `wr_en` is high.
- The read result is combinational in the same cycle.

ROM address translation is purely combinational from the registers and `cpu_addr`.

Top module: `rot_bank_mapper`

## Requirements
- R1: A register write takes effect only if `wr_addr` < 0x010000. Within that range, `wr_addr[11:8]` selects the target: 0xD is the SRAM register, 0xE is the mode register and 0xF is the bank register. Any other value changes nothing.
- R2: The data byte is chosen as follows:
  - A byte write (`wr_word`=0) to an odd address uses `wr_data[7:0]`.
  - A byte write to an even address uses `wr_data[15:8]`.
  - A word write (`wr_word`=1) always uses `wr_data[7:0]`.
- R3: While bit 7 of the mode register is 0, every register write is dropped, including writes to the mode register itself. Only reset leaves this state.
- R4: `sram_map` equals bit 7 of the SRAM register. It changes in the cycle after an accepted write.
- R5: When mode bit 6 is 1, the window number is w = `cpu_addr[20:18]`. Window w is served from bank (bank register bits [6:4] + w) mod 8.
- R6: When mode bit 6 is 0, every window is served from bank = bank register bits [6:4].
- R7: `rom_addr` = {bank, `cpu_addr[17:0]`}, formed combinationally. `cpu_addr[23:21]` has no effect.
- R8: When `rd_en` is high and `rd_addr` is in 0xA13000 to 0xA130FF, `rd_hit` is 1 and `rd_data` = bank register AND 0xF0. Otherwise both are 0.
- R9: After reset the registers hold SRAM=0x00, bank=0x00 and mode=0x80. The mapper is then unlocked, in mirrored mode at bank 0, with `sram_map` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_word | input | 1 | 1 = 16-bit write, 0 = byte write |
| wr_addr | input | 24 | Write byte address |
| wr_data | input | 16 | Write data, both byte lanes |
| rd_en | input | 1 | I/O page read strobe |
| rd_addr | input | 24 | Read address |
| rd_hit | output | 1 | Read falls inside the I/O page |
| rd_data | output | 8 | Bank read-back value |
| cpu_addr | input | 24 | CPU address to translate |
| rom_addr | output | 21 | Translated ROM byte address |
| sram_map | output | 1 | SRAM mapped flag |

## Verification
The bench targets these corner cases:
- **Window 7 in rotating mode.** Its bank must wrap modulo eight. A design that carries into a fourth bit would point past the ROM.
- **Even-address byte writes.** They must use the upper lane. A design that always used the low lane would load the wrong bank index.
- **Writes just outside the register span, and selectors other than D, E and F.** A design with a loose decode would alter the mapping after these.
- **Lock sequence.** After mode bit 7 is cleared, a later attempt to reopen the lock and change the bank must leave the translation, the read-back and the SRAM flag untouched. A reset must then clear the lock. A design that let the mode register write through would silently unlock.

// File: rtl/rot_bank_mapper_pkg.sv
package rot_bank_mapper_pkg;

  typedef struct packed {
    logic [7:0] sram_reg;
    logic [7:0] mode_reg;
    logic [7:0] bank_reg;
  } map_regs_t;

  localparam logic [3:0] SEL_SRAM = 4'hD;
  localparam logic [3:0] SEL_MODE = 4'hE;
  localparam logic [3:0] SEL_BANK = 4'hF;

  localparam int UNLOCK_BIT  = 7;
  localparam int LINEAR_BIT  = 6;
  localparam int SRAM_BIT    = 7;
  localparam int IDX_LSB     = 4;

  localparam map_regs_t REGS_RESET = '{sram_reg: 8'h00, mode_reg: 8'h80, bank_reg: 8'h00};

endpackage

// File: rtl/mapper_ctrl_regs.sv
module mapper_ctrl_regs
  import rot_bank_mapper_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int SPAN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_word,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  output map_regs_t         regs_q
);

  logic       in_span;
  logic       unlocked;
  logic       accept;
  logic [3:0] sel;
  logic [7:0] lane;
  logic       unused_addr_bits;

  assign in_span  = (wr_addr[ADDR_W-1:SPAN_W] == '0);
  assign sel      = wr_addr[11:8];
  assign unlocked = regs_q.mode_reg[UNLOCK_BIT];
  assign accept   = wr_en && in_span && unlocked;
  assign lane     = (wr_word || wr_addr[0]) ? wr_data[7:0] : wr_data[15:8];

  assign unused_addr_bits = ^{wr_addr[SPAN_W-1:12], wr_addr[7:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regs_q <= REGS_RESET;
    end else if (accept) begin
      case (sel)
        SEL_SRAM: regs_q.sram_reg <= lane;
        SEL_MODE: regs_q.mode_reg <= lane;
        SEL_BANK: regs_q.bank_reg <= lane;
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/mapper_window_xlat.sv
module mapper_window_xlat
  import rot_bank_mapper_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int WIN_W   = 18,
  parameter int NUM_WIN = 8,
  localparam int IDX_W  = $clog2(NUM_WIN),
  localparam int ROM_W  = WIN_W + IDX_W
) (
  input  map_regs_t         regs_q,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic [ROM_W-1:0]  rom_addr
);

  logic [IDX_W-1:0] base_idx;
  logic             linear;
  logic [IDX_W-1:0] win_sel;
  logic [IDX_W-1:0] bank_of [NUM_WIN];
  logic             unused_bits;

  assign base_idx = regs_q.bank_reg[IDX_LSB +: IDX_W];
  assign linear   = regs_q.mode_reg[LINEAR_BIT];
  assign win_sel  = cpu_addr[WIN_W +: IDX_W];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam logic [IDX_W-1:0] OFS = IDX_W'(w);
    assign bank_of[w] = linear ? (base_idx + OFS) : base_idx;
  end

  assign rom_addr = {bank_of[win_sel], cpu_addr[WIN_W-1:0]};

  assign unused_bits = ^{cpu_addr[ADDR_W-1:ROM_W], regs_q.sram_reg,
                         regs_q.mode_reg[7], regs_q.mode_reg[5:0],
                         regs_q.bank_reg[7], regs_q.bank_reg[3:0]};

endmodule

// File: rtl/mapper_io_read.sv
module mapper_io_read
  import rot_bank_mapper_pkg::*;
#(
  parameter int          ADDR_W  = 24,
  parameter logic [15:0] IO_PAGE = 16'hA130
) (
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  map_regs_t         regs_q,
  output logic              rd_hit,
  output logic [7:0]        rd_data
);

  logic unused_bits;

  assign rd_hit  = rd_en && (rd_addr[ADDR_W-1:8] == IO_PAGE);
  assign rd_data = rd_hit ? {regs_q.bank_reg[7:4], 4'h0} : 8'h00;

  assign unused_bits = ^{rd_addr[7:0], regs_q.sram_reg, regs_q.mode_reg,
                         regs_q.bank_reg[3:0]};

endmodule

// File: rtl/rot_bank_mapper.sv
module rot_bank_mapper
  import rot_bank_mapper_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int SPAN_W  = 16,
  parameter int WIN_W   = 18,
  parameter int NUM_WIN = 8,
  localparam int ROM_W  = WIN_W + $clog2(NUM_WIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_word,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_hit,
  output logic [7:0]        rd_data,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic [ROM_W-1:0]  rom_addr,
  output logic              sram_map
);

  map_regs_t regs_q;

  mapper_ctrl_regs #(.ADDR_W(ADDR_W), .SPAN_W(SPAN_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_word (wr_word),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .regs_q  (regs_q)
  );

  mapper_window_xlat #(.ADDR_W(ADDR_W), .WIN_W(WIN_W), .NUM_WIN(NUM_WIN)) u_xlat (
    .regs_q   (regs_q),
    .cpu_addr (cpu_addr),
    .rom_addr (rom_addr)
  );

  mapper_io_read #(.ADDR_W(ADDR_W)) u_rd (
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .regs_q  (regs_q),
    .rd_hit  (rd_hit),
    .rd_data (rd_data)
  );

  assign sram_map = regs_q.sram_reg[SRAM_BIT];

endmodule

// File: rtl/rot_bank_mapper_chk.sv
module rot_bank_mapper_chk
  import rot_bank_mapper_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        wr_word,
  input logic [23:0] wr_addr,
  input logic [15:0] wr_data,
  input logic        rd_hit,
  input logic [7:0]  rd_data,
  input logic [23:0] cpu_addr,
  input logic [20:0] rom_addr,
  input logic        sram_map,
  input map_regs_t   regs_q
);

  p_span_ignore_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[23:16] != 8'h00) |=> $stable(regs_q));

  p_odd_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_word && wr_addr[0] && wr_addr[23:16] == 8'h00 &&
     wr_addr[11:8] == 4'hF && regs_q.mode_reg[7])
    |=> regs_q.bank_reg == $past(wr_data[7:0]));

  p_lock_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !regs_q.mode_reg[7] |=> $stable(regs_q));

  p_sram_track_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sram_map == regs_q.sram_reg[7]);

  p_rotate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    regs_q.mode_reg[6] |-> rom_addr[20:18] == 3'(regs_q.bank_reg[6:4] + cpu_addr[20:18]));

  p_mirror_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !regs_q.mode_reg[6] |-> rom_addr[20:18] == regs_q.bank_reg[6:4]);

  p_offset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rom_addr[17:0] == cpu_addr[17:0]);

  p_readback_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |-> rd_data == {regs_q.bank_reg[7:4], 4'h0});

  p_miss_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |-> rd_data == 8'h00);

endmodule

bind rot_bank_mapper rot_bank_mapper_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_word  (wr_word),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .rd_hit   (rd_hit),
  .rd_data  (rd_data),
  .cpu_addr (cpu_addr),
  .rom_addr (rom_addr),
  .sram_map (sram_map),
  .regs_q   (regs_q)
);

// File: tb/rot_bank_mapper_tb_top.sv
module rot_bank_mapper_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_word = 1'b0;
  logic [23:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [23:0] rd_addr = '0;
  logic        rd_hit;
  logic [7:0]  rd_data;
  logic [23:0] cpu_addr = '0;
  logic [20:0] rom_addr;
  logic        sram_map;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  rot_bank_mapper dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_hit(rd_hit), .rd_data(rd_data), .cpu_addr(cpu_addr),
    .rom_addr(rom_addr), .sram_map(sram_map)
  );

  typedef struct packed {
    logic        do_wr;
    logic        word;
    logic [23:0] addr;
    logic [15:0] data;
    logic [23:0] probe;
    logic [20:0] exp_rom;
    logic [7:0]  exp_rd;
    logic        exp_sram;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 24'h000F01, 16'h0030, 24'h1C5678, 21'h0C5678, 8'h30, 1'b0}, // R6 mirror idx3
    '{1'b1, 1'b0, 24'h000E01, 16'h00C0, 24'h1C5678, 21'h085678, 8'h30, 1'b0}, // R5 wrap 3+7
    '{1'b1, 1'b0, 24'h000F00, 16'h5000, 24'h000000, 21'h140000, 8'h50, 1'b0}, // R2 even lane
    '{1'b1, 1'b1, 24'h000D00, 16'hAA80, 24'h07FFFF, 21'h1BFFFF, 8'h50, 1'b1}, // R2 word, R4
    '{1'b1, 1'b0, 24'h010F01, 16'h0070, 24'h07FFFF, 21'h1BFFFF, 8'h50, 1'b1}, // R1 out of span
    '{1'b1, 1'b0, 24'h000C01, 16'h0070, 24'h07FFFF, 21'h1BFFFF, 8'h50, 1'b1}, // R1 bad selector
    '{1'b1, 1'b0, 24'h000F01, 16'h007F, 24'h040000, 21'h000000, 8'h70, 1'b1}, // R8 mask, R5
    '{1'b1, 1'b0, 24'h000E01, 16'h0080, 24'h040000, 21'h1C0000, 8'h70, 1'b1}, // R6
    '{1'b1, 1'b1, 24'h00FD00, 16'h0012, 24'hFFFFFF, 21'h1FFFFF, 8'h70, 1'b0}  // R7 upper bits, R4
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic word, input logic [23:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_word = word; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic probe(input logic [23:0] ca, input logic [23:0] ra);
    cpu_addr = ca; rd_en = 1'b1; rd_addr = ra;
    #1;
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    apply_reset();
    // R9 reset state
    probe(24'h1C0010, 24'hA13001);
    check("R9 rom", 32'(rom_addr), 32'h000010);
    check("R9 rd", 32'(rd_data), 32'h00);
    check("R9 sram", 32'(sram_map), 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].do_wr) do_write(VECS[i].word, VECS[i].addr, VECS[i].data);
      probe(VECS[i].probe, 24'hA13001);
      check($sformatf("R5/R6/R7 vec%0d rom", i), 32'(rom_addr), 32'(VECS[i].exp_rom));
      check($sformatf("R8 vec%0d rd", i), 32'(rd_data), 32'(VECS[i].exp_rd));
      check($sformatf("R4 vec%0d sram", i), 32'(sram_map), 32'(VECS[i].exp_sram));
    end

    // R8 page boundaries
    probe(24'h000000, 24'hA130FF);
    check("R8 top of page hit", 32'(rd_hit), 32'h1);
    check("R8 top of page data", 32'(rd_data), 32'h70);
    probe(24'h000000, 24'hA13100);
    check("R8 past page hit", 32'(rd_hit), 32'h0);
    check("R8 past page data", 32'(rd_data), 32'h00);
    rd_en = 1'b0; #1;
    probe(24'h000000, 24'hA13000); rd_en = 1'b0; #1;
    check("R8 no enable", 32'(rd_hit), 32'h0);

    // R3 lock
    apply_reset();
    do_write(1'b0, 24'h000F01, 16'h0020);
    do_write(1'b0, 24'h000E01, 16'h0040);
    probe(24'h040000, 24'hA13001);
    check("R3 locked rotate", 32'(rom_addr), 32'h0C0000);
    do_write(1'b0, 24'h000E01, 16'h00C0);
    do_write(1'b0, 24'h000F01, 16'h0050);
    do_write(1'b1, 24'h000D00, 16'h0080);
    probe(24'h040000, 24'hA13001);
    check("R3 mapping held", 32'(rom_addr), 32'h0C0000);
    check("R3 readback held", 32'(rd_data), 32'h20);
    check("R3 sram held", 32'(sram_map), 32'h0);
    apply_reset();
    probe(24'h040000, 24'hA13001);
    check("R9 reset clears lock", 32'(rom_addr), 32'h000000);
    do_write(1'b0, 24'h000F01, 16'h0040);
    probe(24'h040000, 24'hA13001);
    check("R9 writable after reset", 32'(rom_addr), 32'h100000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule